// File: doc/BRIEF.md
# Cascadable Up/Down Synchronous Counter

This block is a presettable binary counter whose state changes only on the rising clock edge. Each edge does one of four things. It can force the state to zero, capture a parallel data word, step the count up or down modulo 2^W, or keep the current value. The default is W = 4, which gives a modulo-16 stage.

Two active-low count enables control stepping. The parallel enable is meant to be shared by every stage of a chain. The trickle enable also qualifies an active-low terminal-count flag, so one stage can enable the next without extra gating. That flag is decoded without a register from the present count, the direction select and the trickle enable. It ignores the parallel enable, so it settles as soon as the lower stage reaches its end value.

Chaining several instances, with each flag driving the next stage's trickle enable, gives a wider synchronous counter. All stages share one clock, one load strobe and one direction select.

Top module: `updn_cascade_ctr`

## Requirements
- R1: With `rst` high at a rising edge, the count becomes 0 on that edge, even when `load_n` is low at the same edge.
- R2: With `rst` low and `load_n` low at a rising edge, the count takes the value of `din`, whatever the levels of `en_par_n`, `en_trk_n` and `up_dn`.
- R3: With `load_n` high and both `en_par_n` and `en_trk_n` low, `up_dn` = 1 adds one to the count at the edge, and the all-ones value wraps to 0.
- R4: Under the same enable conditions, `up_dn` = 0 subtracts one from the count, and 0 wraps to the all-ones value.
- R5: With `load_n` high and either `en_par_n` or `en_trk_n` high, the count keeps its value across the edge.
- R6: `tc_n` is 0 exactly when `en_trk_n` is 0 and the count is either all ones with `up_dn` = 1 or zero with `up_dn` = 0. Otherwise `tc_n` is 1. `tc_n` follows its inputs within the same cycle and does not depend on `en_par_n`.
- R7: Stages connected in a chain form a wider counter. Each stage's `tc_n` drives the next stage's `en_trk_n`, and all stages share `clk`, `load_n`, `up_dn` and `en_par_n`. The chain counts up and down modulo 2^(W·stages), with carries and borrows crossing stage boundaries on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| din | input | W | Parallel preset value |
| load_n | input | 1 | Active-low synchronous parallel load |
| up_dn | input | 1 | Direction select: 1 counts up, 0 counts down |
| en_par_n | input | 1 | Active-low parallel count enable |
| en_trk_n | input | 1 | Active-low trickle count enable; also qualifies `tc_n` |
| cnt | output | W | Present count |
| tc_n | output | 1 | Active-low terminal-count flag |

## Verification
The load path is tried with every 4-bit value under all four enable combinations. This separates a true load priority from a load that only happens when counting would have been allowed.

For every start value, both directions and all four enable pairs, one edge is applied. That single step separates increment, decrement and hold, and it exposes wrap errors at 0 and 15. Before the edge, `tc_n` is sampled for the same combinations. This shows whether it follows the trickle enable alone rather than the parallel one, and whether it uses the correct end value for each direction.

A three-stage chain is then run up and down through the 12-bit wrap points and compared with a plain arithmetic reference. This reveals any carry or borrow that lags a cycle between stages.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_UP   = 2'd2,
    OP_DOWN = 2'd3
  } ctr_op_e;

endpackage

// File: rtl/updn_ctr_ctl.sv
module updn_ctr_ctl
  import updn_ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    up_dn,
  input  logic    en_par_n,
  input  logic    en_trk_n,
  output ctr_op_e op,
  output logic    do_load,
  output logic    do_count
);

  // load has precedence over both enables
  assign do_load  = ~load_n;
  assign do_count = load_n & ~en_par_n & ~en_trk_n;

  always_comb begin
    if (do_load)       op = OP_LOAD;
    else if (!do_count) op = OP_HOLD;
    else if (up_dn)     op = OP_UP;
    else                op = OP_DOWN;
  end

endmodule

// File: rtl/updn_ctr_next.sv
module updn_ctr_next
  import updn_ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  ctr_op_e      op,
  output logic [W-1:0] nxt,
  output logic         wrap
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] step_up(input logic [W-1:0] v);
    return (v == TOP) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [W-1:0] step_down(input logic [W-1:0] v);
    return (v == '0) ? TOP : v - 1'b1;
  endfunction

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_UP:   nxt = step_up(cur);
      OP_DOWN: nxt = step_down(cur);
      default: nxt = cur;
    endcase
  end

  assign wrap = ((op == OP_UP) && (cur == TOP)) || ((op == OP_DOWN) && (cur == '0));

endmodule

// File: rtl/updn_ctr_tc.sv
module updn_ctr_tc #(
  parameter int W = 4
) (
  input  logic [W-1:0] cnt,
  input  logic         up_dn,
  input  logic         en_trk_n,
  output logic         tc_n
);

  logic [W-1:0] all_hi;
  logic [W-1:0] all_lo;

  // bitwise look-ahead chains for the two end values
  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      if (b == 0) begin : g_first
        assign all_hi[b] = cnt[b];
        assign all_lo[b] = ~cnt[b];
      end else begin : g_rest
        assign all_hi[b] = all_hi[b-1] & cnt[b];
        assign all_lo[b] = all_lo[b-1] & ~cnt[b];
      end
    end
  endgenerate

  logic at_end;
  assign at_end = up_dn ? all_hi[W-1] : all_lo[W-1];
  assign tc_n   = ~(at_end & ~en_trk_n);

endmodule

// File: rtl/updn_cascade_ctr.sv
module updn_cascade_ctr
  import updn_ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         load_n,
  input  logic         up_dn,
  input  logic         en_par_n,
  input  logic         en_trk_n,
  output logic [W-1:0] cnt,
  output logic         tc_n
);

  ctr_op_e      op;
  logic         do_load;
  logic         do_count;
  logic         wrap;
  logic [W-1:0] nxt;
  logic [W-1:0] cnt_q;

  updn_ctr_ctl ctl_i (
    .load_n   (load_n),
    .up_dn    (up_dn),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .op       (op),
    .do_load  (do_load),
    .do_count (do_count)
  );

  updn_ctr_next #(.W(W)) next_i (
    .cur  (cnt_q),
    .din  (din),
    .op   (op),
    .nxt  (nxt),
    .wrap (wrap)
  );

  updn_ctr_tc #(.W(W)) tc_i (
    .cnt      (cnt_q),
    .up_dn    (up_dn),
    .en_trk_n (en_trk_n),
    .tc_n     (tc_n)
  );

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/updn_ctr_chk.sv
module updn_ctr_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] din,
  input logic         load_n,
  input logic         up_dn,
  input logic         en_par_n,
  input logic         en_trk_n,
  input logic [W-1:0] cnt,
  input logic         tc_n,
  input logic         do_load,
  input logic         do_count,
  input logic         wrap
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cnt == '0);

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(load_n)) |-> cnt == $past(din));

  p_count_up_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(load_n && !en_par_n && !en_trk_n && up_dn))
      |-> cnt == W'($past(cnt) + 1'b1));

  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(load_n && !en_par_n && !en_trk_n && !up_dn))
      |-> cnt == W'($past(cnt) - 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(load_n && (en_par_n || en_trk_n))) |-> $stable(cnt));

  p_tc_qualified_r6: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> (!en_trk_n && (cnt == '0 || cnt == {W{1'b1}})));

  p_wrap_at_tc_r6: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !tc_n);

  p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({do_load, do_count}));

endmodule

bind updn_cascade_ctr updn_ctr_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .load_n   (load_n),
  .up_dn    (up_dn),
  .en_par_n (en_par_n),
  .en_trk_n (en_trk_n),
  .cnt      (cnt),
  .tc_n     (tc_n),
  .do_load  (do_load),
  .do_count (do_count),
  .wrap     (wrap)
);

// File: tb/updn_cascade_ctr_tb_top.sv
module updn_cascade_ctr_tb_top;

  localparam int W  = 4;
  localparam int NS = 3;
  localparam int CW = W * NS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // single stage under test
  logic         rst;
  logic [W-1:0] din;
  logic         load_n, up_dn, en_par_n, en_trk_n;
  logic [W-1:0] cnt;
  logic         tc_n;

  updn_cascade_ctr #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .din(din), .load_n(load_n), .up_dn(up_dn),
    .en_par_n(en_par_n), .en_trk_n(en_trk_n), .cnt(cnt), .tc_n(tc_n)
  );

  // chained stages
  logic [CW-1:0] c_din;
  logic          c_load_n, c_dir, c_en_n;
  logic [NS:0]   trk;
  logic [CW-1:0] c_cnt;

  assign trk[0] = 1'b0;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    updn_cascade_ctr #(.W(W)) chain_i (
      .clk(clk), .rst(rst), .din(c_din[s*W +: W]), .load_n(c_load_n),
      .up_dn(c_dir), .en_par_n(c_en_n), .en_trk_n(trk[s]),
      .cnt(c_cnt[s*W +: W]), .tc_n(trk[s+1])
    );
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_single(input int v);
    @(negedge clk);
    load_n = 1'b0; din = W'(v);
    tick();
  endtask

  initial begin
    rst = 1'b1; din = '0; load_n = 1'b1; up_dn = 1'b1;
    en_par_n = 1'b1; en_trk_n = 1'b1;
    c_din = '0; c_load_n = 1'b1; c_dir = 1'b1; c_en_n = 1'b1;
    tick(); tick();

    // R1: reset wins over a pending load
    @(negedge clk);
    load_n = 1'b0; din = 4'd9;
    tick();
    check("R1", int'(cnt), 0);
    check("R7 reset", int'(c_cnt), 0);
    @(negedge clk);
    rst = 1'b0; load_n = 1'b1;

    // R2: load every value under every enable pair and direction
    for (int v = 0; v < 16; v++) begin
      for (int ec = 0; ec < 4; ec++) begin
        @(negedge clk);
        load_n = 1'b0; din = W'(v);
        en_par_n = ec[1]; en_trk_n = ec[0]; up_dn = ec[0] ^ ec[1];
        tick();
        check("R2", int'(cnt), v);
      end
    end

    // R3 R4 R5 R6: one step from each state, direction and enable pair
    for (int dir = 0; dir < 2; dir++) begin
      for (int v = 0; v < 16; v++) begin
        for (int ec = 0; ec < 4; ec++) begin
          int exp_cnt;
          int exp_tc;
          load_single(v);
          @(negedge clk);
          load_n = 1'b1; up_dn = dir[0];
          en_par_n = ec[1]; en_trk_n = ec[0];
          #1;
          exp_tc = (ec[0] == 0 && ((dir == 1 && v == 15) || (dir == 0 && v == 0))) ? 0 : 1;
          check("R6", int'(tc_n), exp_tc);
          tick();
          if (ec != 0)       begin exp_cnt = v;              check("R5", int'(cnt), exp_cnt); end
          else if (dir == 1) begin exp_cnt = (v + 1) % 16;   check("R3", int'(cnt), exp_cnt); end
          else               begin exp_cnt = (v + 15) % 16;  check("R4", int'(cnt), exp_cnt); end
        end
      end
    end

    // R7: chain counting up through the top wrap
    begin
      int ref_v;
      @(negedge clk);
      c_load_n = 1'b0; c_din = 12'hFF0; c_en_n = 1'b1;
      tick();
      ref_v = 'hFF0;
      check("R7 load", int'(c_cnt), ref_v);
      @(negedge clk);
      c_load_n = 1'b1; c_dir = 1'b1; c_en_n = 1'b0;
      for (int i = 0; i < 40; i++) begin
        tick();
        ref_v = (ref_v + 1) % (1 << CW);
        check("R7 up", int'(c_cnt), ref_v);
      end
      // hold through the parallel enable
      @(negedge clk);
      c_en_n = 1'b1;
      tick(); tick();
      check("R7 hold", int'(c_cnt), ref_v);
      // down through the bottom wrap and a middle borrow
      @(negedge clk);
      c_load_n = 1'b0; c_din = 12'h110;
      tick();
      ref_v = 'h110;
      @(negedge clk);
      c_load_n = 1'b1; c_dir = 1'b0; c_en_n = 1'b0;
      for (int i = 0; i < 300; i++) begin
        tick();
        ref_v = (ref_v + (1 << CW) - 1) % (1 << CW);
        check("R7 down", int'(c_cnt), ref_v);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule